// File: doc/BRIEF.md
# Latched Pushbutton Signal Selector

This block turns nine momentary front-panel pushbuttons into a held selection that steers one of nine signal paths to a shared measurement instrument. The buttons come in three groups of three: received RF for antennas 1 to 3, transmitted RF for antennas 1 to 3, and intermediate frequency (IF) for antennas 1 to 3. Each button input is active low and idles high. Each input passes through a synchroniser and a debounce filter. A qualified press then loads a 4-bit selection code. The code stays loaded after the button is released and changes only when another button is pressed.

The held code drives a decoder with nine select lines, and exactly one of them is active. Each select line closes its routing switch and lights the lamp under its own button. A lamp-test input turns on every lamp and leaves the held selection and the routing lines as they are. Eight of the buttons go through a priority encoder that sets the low three code bits. The ninth button bypasses the encoder and sets the code MSB directly. The button-to-code mapping is therefore fixed and does not follow the panel grouping.

Top module: `sig_selector`

## Requirements
- R1: After reset the held code is 4'b0000. Only select line 0 (received RF, antenna 1) is active, and only lamp 0 is lit.
- R2: Button input bit i of `btn_n_i` gives the following held codes: bit 0 received ant1 = 0000, bit 1 received ant2 = 0001, bit 2 received ant3 = 0010, bit 3 transmitted ant1 = 0011, bit 4 transmitted ant2 = 0100, bit 5 IF ant1 = 0101, bit 6 IF ant2 = 0110, bit 7 IF ant3 = 0111, bit 8 transmitted ant3 = 1000.
- R3: Releasing a button leaves the held code and all outputs unchanged. Only a new qualified press changes them.
- R4: Exactly one bit of `route_o` is active at all times, and it is the bit whose index equals the held code.
- R5: With lamp test low, `lamp_o` equals `route_o`, so exactly one lamp is lit.
- R6: With lamp test high, all nine lamps are lit while `route_o` and `code_o` keep their values. When lamp test drops, the lamps return to the held selection.
- R7: When several of buttons 0 to 7 are qualified together, the one with the highest bit index sets the code.
- R8: Button 8 pressed with any others gives code 1000.
- R9: A low pulse shorter than `DEBOUNCE_CYCLES` consecutive synchronised samples leaves the held code unchanged.
- R10: An input held at its idle high level has no effect on the held code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_n_i | input | 9 | Momentary buttons, active low, idle high |
| lamp_test_i | input | 1 | Forces all lamps on while high |
| code_o | output | 4 | Held selection code |
| route_o | output | 9 | One-hot routing switch controls |
| lamp_o | output | 9 | Lamp drive, active high |

## Verification
The bench builds the block with `DEBOUNCE_CYCLES` = 4 and `SYNC_STAGES` = 3. These values keep a full press-to-load latency to a few cycles. A 2-cycle glitch can then be placed below the filter threshold, and a 3-stage synchroniser variant is elaborated as well. With these values the bench can walk every button's code, compare simultaneous presses, check the button-8 override, and hold lamp test across a held selection, all within a short run.

// File: rtl/sig_selector_pkg.sv
package sig_selector_pkg;
   localparam int NUM_BTN     = 9;
   localparam int ENC_INPUTS  = 8;
   localparam int ENC_W       = $clog2(ENC_INPUTS);
   localparam int CODE_W      = ENC_W + 1;
   localparam int DIRECT_BTN  = NUM_BTN - 1;
   typedef logic [CODE_W-1:0]  code_t;
   typedef logic [NUM_BTN-1:0] lines_t;
endpackage

// File: rtl/selbtn_cond.sv
module selbtn_cond #(
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 1_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic btn_n_i,
   output logic pressed_o
);
   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
      if (DEBOUNCE_CYCLES < 1) $error("DEBOUNCE_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   raw_press;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '1;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], btn_n_i};
   end

   assign raw_press = ~sync_q[SYNC_STAGES-1];

   generate
      if (DEBOUNCE_CYCLES <= 1) begin : g_no_filter
         assign pressed_o = raw_press;
      end else begin : g_filter
         localparam int CNT_W = $clog2(DEBOUNCE_CYCLES);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);
         logic [CNT_W-1:0] cnt_q;
         logic             stable_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q    <= '0;
               stable_q <= 1'b0;
            end else if (raw_press != stable_q) begin
               if (cnt_q == CNT_LAST) begin
                  stable_q <= raw_press;
                  cnt_q    <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else begin
               cnt_q <= '0;
            end
         end

         assign pressed_o = stable_q;
      end
   endgenerate
endmodule

// File: rtl/sel_encoder.sv
module sel_encoder
   import sig_selector_pkg::*;
(
   input  lines_t pressed_i,
   output logic   valid_o,
   output code_t  code_o
);
   always_comb begin
      valid_o = |pressed_i;
      code_o  = '0;
      for (int i = 0; i < ENC_INPUTS; i++) begin
         if (pressed_i[i]) code_o = {1'b0, ENC_W'(i)};
      end
      if (pressed_i[DIRECT_BTN]) code_o = {1'b1, {ENC_W{1'b0}}};
   end
endmodule

// File: rtl/sel_decoder.sv
module sel_decoder
   import sig_selector_pkg::*;
(
   input  code_t  code_i,
   output lines_t lines_o
);
   generate
      for (genvar i = 0; i < NUM_BTN; i++) begin : g_line
         assign lines_o[i] = (code_i == CODE_W'(i));
      end
   endgenerate
endmodule

// File: rtl/sig_selector.sv
module sig_selector
   import sig_selector_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 1_000_000
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [8:0]   btn_n_i,
   input  logic         lamp_test_i,
   output logic [3:0]   code_o,
   output logic [8:0]   route_o,
   output logic [8:0]   lamp_o
);
   lines_t pressed;
   logic   enc_valid;
   code_t  enc_code;
   code_t  held_q;
   lines_t dec_lines;

   generate
      for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
         selbtn_cond #(
            .SYNC_STAGES    (SYNC_STAGES),
            .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
         ) u_cond (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .btn_n_i  (btn_n_i[b]),
            .pressed_o(pressed[b])
         );
      end
   endgenerate

   sel_encoder u_enc (
      .pressed_i(pressed),
      .valid_o  (enc_valid),
      .code_o   (enc_code)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        held_q <= '0;
      else if (enc_valid) held_q <= enc_code;
   end

   sel_decoder u_dec (
      .code_i (held_q),
      .lines_o(dec_lines)
   );

   assign code_o  = held_q;
   assign route_o = dec_lines;
   assign lamp_o  = dec_lines | {NUM_BTN{lamp_test_i}};
endmodule

// File: rtl/sig_selector_chk.sv
module sig_selector_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [8:0] pressed,
   input logic       lamp_test_i,
   input logic [3:0] code_o,
   input logic [8:0] route_o,
   input logic [8:0] lamp_o
);
   // R4
   a_r4_one_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(route_o) == 1);
   // R2, R4
   a_r2_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_o <= 4'd8);
   // R5
   a_r5_single_lamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lamp_test_i |-> $countones(lamp_o) == 1);
   // R6
   a_r6_all_lamps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lamp_test_i |-> lamp_o == 9'h1FF);
   // R3, R10
   a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pressed == 9'd0) |=> $stable(code_o));
   // R8
   a_r8_direct_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pressed[8] |=> code_o == 4'd8);
endmodule

bind sig_selector sig_selector_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .pressed    (pressed),
   .lamp_test_i(lamp_test_i),
   .code_o     (code_o),
   .route_o    (route_o),
   .lamp_o     (lamp_o)
);

// File: tb/sig_selector_bench.sv
`timescale 1ns/1ps
module sig_selector_bench;
   localparam int DEB  = 4;
   localparam int SYNC = 3;
   localparam int SETTLE = DEB + SYNC + 6;

   typedef struct {
      int    code;
      bit    lt;
      string req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] btn_n = 9'h1FF;
   logic       lamp_test = 1'b0;
   logic [3:0] code;
   logic [8:0] route;
   logic [8:0] lamp;

   int checks = 0;
   int errors = 0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   sig_selector #(.SYNC_STAGES(SYNC), .DEBOUNCE_CYCLES(DEB)) u_sig_selector (
      .clk_i(clk), .rst_ni(rst_n), .btn_n_i(btn_n), .lamp_test_i(lamp_test),
      .code_o(code), .route_o(route), .lamp_o(lamp)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops expected items and compares against outputs
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0) begin
            exp_t e;
            int   one;
            e   = q.pop_front();
            one = 1 << e.code;
            chk(e.req, "code", int'(code), e.code);
            chk(e.req, "route", int'(route), one);
            chk(e.req, "lamp", int'(lamp), e.lt ? 32'h1FF : one);
         end
      end
   end

   task automatic expect_now(input int c, input bit lt, input string req);
      exp_t e;
      e.code = c; e.lt = lt; e.req = req;
      q.push_back(e);
      repeat (2) @(negedge clk);
   endtask

   task automatic drive(input logic [8:0] mask, input int cycles);
      @(negedge clk);
      btn_n = ~mask;
      repeat (cycles) @(negedge clk);
   endtask

   task automatic press(input logic [8:0] mask, input int c, input string req);
      drive(mask, SETTLE);
      expect_now(c, 1'b0, req);
      drive(9'h000, SETTLE);
      expect_now(c, 1'b0, "R3 release");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      expect_now(0, 1'b0, "R1 reset");
      // R10: idle inputs keep reset selection
      repeat (SETTLE) @(negedge clk);
      expect_now(0, 1'b0, "R10 idle");
      // R2: each button code
      press(9'b000000010, 1, "R2 rx2");
      press(9'b000000100, 2, "R2 rx3");
      press(9'b000001000, 3, "R2 tx1");
      press(9'b000010000, 4, "R2 tx2");
      press(9'b000100000, 5, "R2 if1");
      press(9'b001000000, 6, "R2 if2");
      press(9'b010000000, 7, "R2 if3");
      press(9'b100000000, 8, "R2 tx3");
      press(9'b000000001, 0, "R2 rx1");
      // R9: short glitch ignored
      drive(9'b000100000, 2);
      drive(9'h000, SETTLE);
      expect_now(0, 1'b0, "R9 glitch");
      // R7: highest index among 0..7 wins
      press(9'b001000110, 6, "R7 multi");
      press(9'b000001001, 3, "R7 pair");
      // R8: direct button overrides
      press(9'b110000001, 8, "R8 override");
      // R6: lamp test
      press(9'b000010000, 4, "R2 tx2 again");
      @(negedge clk); lamp_test = 1'b1;
      @(negedge clk);
      expect_now(4, 1'b1, "R6 lamp test on");
      @(negedge clk); lamp_test = 1'b0;
      @(negedge clk);
      expect_now(4, 1'b0, "R6 lamp test off R5");
      repeat (4) @(negedge clk);
      chk("R6", "queue drained", q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule